// File: doc/BRIEF.md
# Receive FIFO Wide Read Port

This block sits between a host bus read path and up to eight serial receive FIFOs. It lets a bus master empty a channel's 64-entry receive FIFO through word-wide reads instead of one register read per byte. Every channel owns a pair of 256-byte address pages. The odd page holds a data window that packs up to four successive FIFO bytes into one 32-bit word. It also holds a combined window that returns each byte next to its line-status flags. The even page keeps a byte-wide holding-register location for legacy single-byte access.

Requests and responses each use a valid/ready handshake. A request is accepted when `req_valid` and `req_ready` are both high. The FIFO pops for that access are driven in the same cycle. The response appears one cycle later and stays on the output until `rsp_ready` takes it. While a response is pending and not taken, `req_ready` stays low, so no FIFO entry is popped whose data could not be delivered. The FIFOs show their four oldest entries, with status, on peek buses. They take a pop count per channel.

Top module: `rx_wide_read_port`

## Requirements
- R1: Address bits [11:9] select the channel and bit 8 selects the page. On an odd page, offsets 0x00–0x3F are the data window and offsets 0x80–0xFF are the combined window. On an even page, offset 0x00 is the holding register. Channel 2's data window therefore starts at 0x500. Only the addressed channel's pop count is ever nonzero.
- R2: In the data window, the enabled byte lanes are taken in ascending lane order. Each takes the next-oldest FIFO entry, so with all four lanes enabled the oldest byte is in lane 0 (bits 7:0) and the newest is in lane 3 (bits 31:24).
- R3: Accesses of 8, 16, 24 or 32 bits, or any other set of byte enables, are accepted in the data window. Only enabled lanes pop entries. Disabled lanes read 0x00.
- R4: In the combined window, half-word h (lanes 2h and 2h+1) is active only when both of its lanes are enabled. It carries the entry's data byte in its low lane and that entry's status byte in its high lane. A 32-bit read pops two entries. A half-word with only one lane enabled reads zero and pops nothing.
- R5: The holding register returns one entry in lane 0 only when the byte enables are exactly 4'b0001. Any other enable pattern there reads zero and pops nothing.
- R6: An active lane or half-word whose entry is not in the FIFO reads 0x00 and pops nothing, and `rsp_underflow` is 1 for that response. Otherwise `rsp_underflow` is 0.
- R7: All pops of one access are driven on `fifo_pop_num` in the cycle the request is accepted. The response is valid in the next cycle.
- R8: Writes, offsets 0x40–0x7F of an odd page, nonzero offsets of an even page and channels at or above NUM_CH are accepted but pop nothing. They return zero data with `rsp_underflow` 0.
- R9: `req_ready` is high exactly when no response is pending or `rsp_ready` is high. A pending response holds its data and flag unchanged until taken.
- R10: After reset, no response is pending, `req_ready` is high and no pop is driven.
- R11: Sixteen back-to-back 32-bit reads of the data window drain a full 64-entry FIFO in arrival order, one accepted read per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | Request is a write (ignored) |
| req_addr | input | 12 | Byte address |
| req_be | input | 4 | Byte-lane enables |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 32 | Read word |
| rsp_underflow | output | 1 | An active lane found its FIFO empty |
| fifo_count | input | 56 | Per-channel fill level, 7 bits each |
| fifo_peek_data | input | 256 | Per channel, four oldest data bytes, entry k at bits [8k+7:8k] |
| fifo_peek_stat | input | 256 | Per channel, status bytes in the same layout |
| fifo_pop_num | output | 24 | Per-channel pop count, 3 bits each |

## Verification
A wrong lane-to-entry mapping shows at once, in the response word of the same read: a byte lands in the wrong lane or pairs with the wrong status. A wrong pop count shows only later. The FIFO head shifts, so every later read of that channel returns bytes offset from the expected stream, and the final fill levels disagree. Pops are also compared directly in the acceptance cycle. Pops on another channel or during a stall break the stream of an untouched channel. They also trip the per-cycle pop checks.

// File: rtl/rxwp_pkg.sv
package rxwp_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_DATA = 2'd1,
    WIN_STAT = 2'd2,
    WIN_HOLD = 2'd3
  } rxwp_win_e;
endpackage

// File: rtl/rxwp_decode.sv
module rxwp_decode
  import rxwp_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12,
  localparam int CH_W = ADDR_W - 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  output rxwp_win_e         win,
  output logic [CH_W-1:0]   chan
);
  logic ch_ok;

  assign chan = addr[ADDR_W-1:9];

  generate
    if (NUM_CH < (1 << CH_W)) begin : g_partial
      assign ch_ok = (int'(chan) < NUM_CH);
    end else begin : g_full
      assign ch_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    win = WIN_NONE;
    if (!write && ch_ok) begin
      if (addr[8]) begin
        if (addr[7])       win = WIN_STAT;
        else if (!addr[6]) win = WIN_DATA;
      end else if (addr[7:0] == 8'h00) begin
        win = WIN_HOLD;
      end
    end
  end
endmodule

// File: rtl/rxwp_chan_sel.sv
module rxwp_chan_sel #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 7,
  parameter int POP_W  = 3,
  parameter int LANES  = 4,
  parameter int CH_W   = 3
) (
  input  logic [CH_W-1:0]             chan,
  input  logic                        fire,
  input  logic [POP_W-1:0]            pop_cnt,
  input  logic [NUM_CH*CNT_W-1:0]     all_count,
  input  logic [NUM_CH*LANES*8-1:0]   all_data,
  input  logic [NUM_CH*LANES*8-1:0]   all_stat,
  output logic [CNT_W-1:0]            sel_count,
  output logic [LANES*8-1:0]          sel_data,
  output logic [LANES*8-1:0]          sel_stat,
  output logic [NUM_CH*POP_W-1:0]     pop_num
);
  always_comb begin
    sel_count = '0;
    sel_data  = '0;
    sel_stat  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chan == CH_W'(c)) begin
        sel_count = all_count[c*CNT_W +: CNT_W];
        sel_data  = all_data[c*LANES*8 +: LANES*8];
        sel_stat  = all_stat[c*LANES*8 +: LANES*8];
      end
    end
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_pop
      assign pop_num[c*POP_W +: POP_W] =
        (fire && chan == CH_W'(c)) ? pop_cnt : '0;
    end
  endgenerate
endmodule

// File: rtl/rxwp_lane_pack.sv
module rxwp_lane_pack
  import rxwp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 7,
  parameter int POP_W = 3
) (
  input  rxwp_win_e            win,
  input  logic [LANES-1:0]     be,
  input  logic [CNT_W-1:0]     count,
  input  logic [LANES*8-1:0]   peek_data,
  input  logic [LANES*8-1:0]   peek_stat,
  output logic [LANES*8-1:0]   word,
  output logic [POP_W-1:0]     pops,
  output logic                 underflow
);
  localparam int HALVES = LANES / 2;

  int slot;

  always_comb begin
    word      = '0;
    underflow = 1'b0;
    slot      = 0;
    unique case (win)
      WIN_DATA: begin
        for (int i = 0; i < LANES; i++) begin
          if (be[i]) begin
            if (slot < int'(count)) word[i*8 +: 8] = peek_data[slot*8 +: 8];
            else                    underflow = 1'b1;
            slot = slot + 1;
          end
        end
      end
      WIN_STAT: begin
        for (int h = 0; h < HALVES; h++) begin
          if (be[2*h] && be[2*h+1]) begin
            if (slot < int'(count)) begin
              word[(2*h)*8 +: 8]   = peek_data[slot*8 +: 8];
              word[(2*h+1)*8 +: 8] = peek_stat[slot*8 +: 8];
            end else begin
              underflow = 1'b1;
            end
            slot = slot + 1;
          end
        end
      end
      WIN_HOLD: begin
        if (be == LANES'(1)) begin
          if (count != '0) word[7:0] = peek_data[7:0];
          else             underflow = 1'b1;
          slot = 1;
        end
      end
      default: begin
        slot = 0;
      end
    endcase
    pops = (slot < int'(count)) ? POP_W'(slot) : POP_W'(count);
  end
endmodule

// File: rtl/rx_wide_read_port.sv
module rx_wide_read_port
  import rxwp_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int POP_W = $clog2(LANES + 1),
  localparam int CH_W  = ADDR_W - 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [LANES-1:0]           req_be,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DATA_W-1:0]          rsp_data,
  output logic                       rsp_underflow,
  input  logic [NUM_CH*CNT_W-1:0]    fifo_count,
  input  logic [NUM_CH*LANES*8-1:0]  fifo_peek_data,
  input  logic [NUM_CH*LANES*8-1:0]  fifo_peek_stat,
  output logic [NUM_CH*POP_W-1:0]    fifo_pop_num
);
  rxwp_win_e           win;
  logic [CH_W-1:0]     chan;
  logic [CNT_W-1:0]    sel_count;
  logic [DATA_W-1:0]   sel_data;
  logic [DATA_W-1:0]   sel_stat;
  logic [DATA_W-1:0]   packed_word;
  logic [POP_W-1:0]    pop_cnt;
  logic                pack_uf;
  logic                accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  rxwp_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .write(req_write),
    .win  (win),
    .chan (chan)
  );

  rxwp_chan_sel #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .POP_W(POP_W), .LANES(LANES), .CH_W(CH_W)
  ) u_sel (
    .chan     (chan),
    .fire     (accept),
    .pop_cnt  (pop_cnt),
    .all_count(fifo_count),
    .all_data (fifo_peek_data),
    .all_stat (fifo_peek_stat),
    .sel_count(sel_count),
    .sel_data (sel_data),
    .sel_stat (sel_stat),
    .pop_num  (fifo_pop_num)
  );

  rxwp_lane_pack #(.LANES(LANES), .CNT_W(CNT_W), .POP_W(POP_W)) u_pack (
    .win      (win),
    .be       (req_be),
    .count    (sel_count),
    .peek_data(sel_data),
    .peek_stat(sel_stat),
    .word     (packed_word),
    .pops     (pop_cnt),
    .underflow(pack_uf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      rsp_underflow <= 1'b0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_data      <= packed_word;
      rsp_underflow <= pack_uf;
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/rxwp_checker.sv
module rxwp_checker #(
  parameter int NUM_CH = 8,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int POP_W = $clog2(LANES + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       req_write,
  input logic [ADDR_W-1:0]          req_addr,
  input logic [LANES-1:0]           req_be,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [DATA_W-1:0]          rsp_data,
  input logic                       rsp_underflow,
  input logic [NUM_CH*CNT_W-1:0]    fifo_count,
  input logic [NUM_CH*LANES*8-1:0]  fifo_peek_data,
  input logic [NUM_CH*LANES*8-1:0]  fifo_peek_stat,
  input logic [NUM_CH*POP_W-1:0]    fifo_pop_num
);
  logic [NUM_CH-1:0] pop_any;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign pop_any[c] = |fifo_pop_num[c*POP_W +: POP_W];
    // R6
    pop_within_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      CNT_W'(fifo_pop_num[c*POP_W +: POP_W]) <= fifo_count[c*CNT_W +: CNT_W]);
  end

  // R1
  one_channel_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_any));

  // R7
  pop_only_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pop_any) |-> (req_valid && req_ready));

  // R7
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_data) && $stable(rsp_underflow)));

  // R8
  write_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (pop_any == '0));

  // R8
  write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (rsp_data == '0 && !rsp_underflow));
endmodule

bind rx_wide_read_port rxwp_checker #(
  .NUM_CH(NUM_CH), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/sim_rx_wide_read_port.sv
`timescale 1ns/1ps
module sim_rx_wide_read_port;
  localparam int NCH = 8;
  localparam int DEP = 64;
  localparam int CW  = 7;
  localparam int PW  = 3;
  localparam int K_NONE = 0, K_DATA = 1, K_STAT = 2, K_HOLD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic req_ready, rsp_valid, rsp_underflow;
  logic [31:0] rsp_data;
  logic [NCH*CW-1:0]   fifo_count;
  logic [NCH*32-1:0]   fifo_peek_data, fifo_peek_stat;
  logic [NCH*PW-1:0]   fifo_pop_num;

  always #2 clk = ~clk;

  rx_wide_read_port u0 (.*);

  // FIFO model driven by the design's pop counts
  logic [7:0] mem_d [NCH][DEP];
  logic [7:0] mem_s [NCH][DEP];
  int mdl_rd [NCH];
  int mdl_cnt [NCH];
  logic push_en = 1'b0;
  int push_ch = 0;
  logic [7:0] push_d = '0, push_s = '0;

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        mdl_rd[c]  <= 0;
        mdl_cnt[c] <= 0;
      end else begin
        int p;
        int add;
        p = int'(fifo_pop_num[c*PW +: PW]);
        add = (push_en && push_ch == c) ? 1 : 0;
        if (add == 1) begin
          mem_d[c][(mdl_rd[c] + mdl_cnt[c]) % DEP] <= push_d;
          mem_s[c][(mdl_rd[c] + mdl_cnt[c]) % DEP] <= push_s;
        end
        mdl_rd[c]  <= (mdl_rd[c] + p) % DEP;
        mdl_cnt[c] <= mdl_cnt[c] - p + add;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      fifo_count[c*CW +: CW] = CW'(mdl_cnt[c]);
      for (int k = 0; k < 4; k++) begin
        fifo_peek_data[(c*4+k)*8 +: 8] = mem_d[c][(mdl_rd[c] + k) % DEP];
        fifo_peek_stat[(c*4+k)*8 +: 8] = mem_s[c][(mdl_rd[c] + k) % DEP];
      end
    end
  end

  int total = 0, bad = 0;
  int exp_rd [NCH];
  int exp_cnt [NCH];
  logic [32:0] exp_q [$];
  string tag_q [$];
  bit finished = 1'b0;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares responses as they are taken, and while stalled
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected response", {31'd0, rsp_underflow, rsp_data}, 64'd0);
      end else begin
        check({rsp_underflow, rsp_data} == exp_q[0], tag_q[0],
              {31'd0, rsp_underflow, rsp_data}, {31'd0, exp_q[0]});
        if (rsp_ready) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
    end
  end

  task automatic fill(int ch, int n, logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      push_en = 1'b1;
      push_ch = ch;
      push_d  = base + 8'(i);
      push_s  = (base + 8'(i)) ^ 8'hA5;
      exp_cnt[ch]++;
    end
    @(posedge clk); #1;
    push_en = 1'b0;
  endtask

  task automatic issue(logic [11:0] addr, logic [3:0] be, bit wr, int kind,
                       int ch, string tag);
    logic [31:0] d;
    bit uf;
    int slot;
    int pops;
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = addr;
    req_be    = be;
    req_write = wr;
    #1;
    while (!req_ready) begin
      @(posedge clk); #2;
    end
    d = '0; uf = 1'b0; slot = 0;
    if (kind == K_DATA) begin
      for (int i = 0; i < 4; i++) if (be[i]) begin
        if (slot < exp_cnt[ch]) d[i*8 +: 8] = mem_d[ch][(exp_rd[ch] + slot) % DEP];
        else uf = 1'b1;
        slot++;
      end
    end else if (kind == K_STAT) begin
      for (int h = 0; h < 2; h++) if (be[2*h +: 2] == 2'b11) begin
        if (slot < exp_cnt[ch]) begin
          d[h*16 +: 8]     = mem_d[ch][(exp_rd[ch] + slot) % DEP];
          d[h*16 + 8 +: 8] = mem_s[ch][(exp_rd[ch] + slot) % DEP];
        end else uf = 1'b1;
        slot++;
      end
    end else if (kind == K_HOLD && be == 4'b0001) begin
      if (exp_cnt[ch] > 0) d[7:0] = mem_d[ch][exp_rd[ch]];
      else uf = 1'b1;
      slot = 1;
    end
    pops = (slot < exp_cnt[ch]) ? slot : exp_cnt[ch];
    // R7: pops appear in the acceptance cycle, on the addressed channel only (R1)
    check(fifo_pop_num == (NCH*PW)'(pops) << (ch*PW), {"R7/R1 pop ", tag},
          64'(fifo_pop_num), 64'((NCH*PW)'(pops) << (ch*PW)));
    exp_rd[ch]  = (exp_rd[ch] + pops) % DEP;
    exp_cnt[ch] = exp_cnt[ch] - pops;
    exp_q.push_back({uf, d});
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic drain();
    idle();
    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      exp_rd[c] = 0;
      exp_cnt[c] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(!rsp_valid && req_ready && fifo_pop_num == '0, "R10 reset state",
          {61'd0, rsp_valid, req_ready, |fifo_pop_num}, {61'd0, 3'b010});

    // R2, R3 on channel 0
    fill(0, 10, 8'h10);
    issue(12'h100, 4'b1111, 0, K_DATA, 0, "R2 full word order");
    issue(12'h104, 4'b0001, 0, K_DATA, 0, "R3 byte read");
    issue(12'h108, 4'b1100, 0, K_DATA, 0, "R3 upper half-word");
    issue(12'h10C, 4'b0111, 0, K_DATA, 0, "R3 three-byte read");
    issue(12'h100, 4'b1010, 0, K_DATA, 0, "R3 sparse lanes");
    drain();

    // R8 ignored accesses, then prove the FIFO head did not move
    issue(12'h100, 4'b1111, 1, K_NONE, 0, "R8 write to data window");
    issue(12'h140, 4'b1111, 0, K_NONE, 0, "R8 gap offset");
    issue(12'h004, 4'b0001, 0, K_NONE, 0, "R8 even page nonzero offset");
    issue(12'h100, 4'b0001, 0, K_DATA, 0, "R8 head unchanged after ignored");
    drain();

    // R4 combined window on channel 3
    fill(3, 6, 8'h60);
    issue(12'h780, 4'b1111, 0, K_STAT, 3, "R4 two data+status pairs");
    issue(12'h7C0, 4'b0110, 0, K_STAT, 3, "R4 split half-words");
    issue(12'h784, 4'b1100, 0, K_STAT, 3, "R4 upper half-word");
    issue(12'h7FC, 4'b1111, 0, K_STAT, 3, "R4/R6 pair past end");
    drain();

    // R5 holding register on channel 2 page 0x400
    fill(2, 3, 8'hC0);
    issue(12'h400, 4'b0001, 0, K_HOLD, 2, "R5 holding byte");
    issue(12'h400, 4'b0011, 0, K_NONE, 2, "R5 wide holding access");
    issue(12'h500, 4'b0001, 0, K_DATA, 2, "R5 head after wide holding");
    issue(12'h400, 4'b0001, 0, K_HOLD, 2, "R5 last holding byte");
    issue(12'h400, 4'b0001, 0, K_HOLD, 2, "R6 holding empty");
    drain();

    // R6 underflow on channel 1
    fill(1, 2, 8'h30);
    issue(12'h300, 4'b1111, 0, K_DATA, 1, "R6 partial underflow");
    issue(12'h300, 4'b0001, 0, K_DATA, 1, "R6 empty byte read");
    drain();

    // R11 burst drain of a full FIFO on channel 2 (window 0x500, R1)
    fill(2, 64, 8'h00);
    for (int k = 0; k < 16; k++)
      issue(12'h500 + 12'(4*k), 4'b1111, 0, K_DATA, 2, "R11 burst word");
    issue(12'h500, 4'b1111, 0, K_DATA, 2, "R11 after full drain");
    drain();

    // R9 back-pressure
    fill(5, 8, 8'h80);
    rsp_ready = 1'b0;
    issue(12'hB00, 4'b1111, 0, K_DATA, 5, "R9 held response A");
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rsp_ready = 1'b1;
      end
    join_none
    @(posedge clk); #2;
    check(!req_ready && fifo_pop_num == '0, "R9 stall blocks request",
          {62'd0, req_ready, |fifo_pop_num}, 64'd0);
    issue(12'hB00, 4'b1111, 0, K_DATA, 5, "R9 response B after stall");
    drain();

    // R1/R8: no channel changed level except by its own reads
    for (int c = 0; c < NCH; c++)
      check(mdl_cnt[c] == exp_cnt[c], "R1 final fill level",
            64'(mdl_cnt[c]), 64'(exp_cnt[c]));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule